// File: doc/BRIEF.md
# Codec Host Register and PIO Sample Interface

This block is the byte-wide host face of an audio codec. A host reaches it through four byte ports selected by a two-bit address: an index port, an indexed-data port, a status port and a shared programmed-I/O data port. Through the index port the host chooses one of a small set of indexed control registers. These registers set the sample format (8 or 16 bits per channel, mono or stereo), enable the capture and playback directions, and enable the interrupt pin.

The block also holds the two byte-sequencing engines. A capture sample arrives on a valid strobe. The host then drains it one byte per read of the PIO port, low byte before high byte and left channel before right channel. A playback sample is built from successive host writes to the same port and is released on a playback request strobe. The status port reports, for each direction, which byte and which channel come next and whether a transfer is due. It also holds a sticky interrupt bit and a combined overrun/underrun flag. Per-direction transfer requests go to an external mover, and these stop while the interrupt is pending if the host has asked for that.

Top module: `codec_pio_regs`

## Requirements
- R1: After reset the index port reads 40h. It holds the register selector in bits 7:4, a transfer-stop control in bit 2 and a format-unlock control in bit 1. Bit 3 reads 0, and bit 0 reads 1 only while initialisation is in progress.
- R2: While `init_busy` is high, reads of the index and indexed-data ports return 80h and writes to both ports have no effect.
- R3: Indexed register 0 (format: bit 1 = 16-bit, bit 0 = stereo) and indexed register 1 (bit 1 = capture enable, bit 0 = playback enable) take a write only while the unlock bit is set. Writes at other times leave them unchanged.
- R4: While the transfer-stop bit is set and the interrupt bit is set, `cap_drq` and `pb_drq` are both low. Otherwise `pb_drq` is high when playback is enabled and a sample is incomplete, and `cap_drq` is high when capture is enabled and capture data is ready.
- R5: Status bit 7 is set by an `irq_event` pulse, stays set, and is cleared by a host write of any value to the status port (port 2).
- R6: The `irq` output follows status bit 7 only while indexed register 2 bit 1 (interrupt enable) is set, and is low otherwise.
- R7: Status bits 0, 1 and 2 give capture upper-byte (1 = high byte or 8-bit mode), left-channel (1 = left or mono) and data-ready. Bits 4, 5 and 6 give the same for playback, where bit 6 means room for more data. Bit 3 is the OR of the overrun and underrun flags.
- R8: Each PIO read returns the next capture byte, in the order left low, left high, right low, right high (8-bit formats use only the low byte of each channel, and mono uses only the left). After the last byte, reads repeat it until a new sample arrives, and that sample restarts the order at the first byte.
- R9: Each PIO write fills the next playback byte in the same order. Once the sample is complete, further writes are ignored. A `pb_req` then presents the sample on `pb_data` as {right[15:0], left[15:0]} with unwritten bytes zero, and empties the buffer.
- R10: A capture sample that arrives while the previous one still has unread bytes sets `ovr_flag`. A sample that arrives with nothing unread clears it.
- R11: A `pb_req` that arrives before the playback sample is complete sets `unr_flag` and leaves `pb_data` unchanged. A `pb_req` with a complete sample clears it. Indexed register 3 reads {6'b0, unr, ovr}.
- R12: Indexed register numbers 4 to 15 read as 00h and ignore writes. Indexed register 3 ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_busy | input | 1 | Codec initialisation in progress |
| irq_event | input | 1 | Interrupt condition pulse from the transfer counter |
| bus_addr | input | 2 | Port select: 0 index, 1 indexed data, 2 status, 3 PIO data |
| bus_wr | input | 1 | Host write strobe, one cycle |
| bus_rd | input | 1 | Host read strobe, one cycle |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data for the addressed port |
| cap_valid | input | 1 | New capture sample present on cap_data |
| cap_data | input | 32 | Capture sample {right, left} |
| pb_req | input | 1 | Converter wants the next playback sample |
| pb_data | output | 32 | Last released playback sample {right, left} |
| cap_drq | output | 1 | Capture transfer request |
| pb_drq | output | 1 | Playback transfer request |
| irq | output | 1 | Interrupt pin |
| ovr_flag | output | 1 | Capture overrun on the most recent sample |
| unr_flag | output | 1 | Playback underrun on the most recent request |

## Verification
The bound checker watches every cycle for these properties: the 80h read-back during initialisation, the sticky set and write-clear of the interrupt bit, the pin's dependence on the enable, the silence of both transfer requests under the stop condition, and the two pointers that hold still once a sample is exhausted or full. The byte order within each format, the values the status bits take as the pointers advance, and the overrun and underrun flags need whole scenarios, so only the bench's sequences show them. The same holds for the unlock gate on the format registers and the data assembled into `pb_data`.

// File: rtl/codec_pio_pkg.sv
package codec_pio_pkg;
   localparam int BYTE_W = 8;
   localparam int CH_W   = 16;

   typedef enum logic [1:0] {
      PORT_INDEX  = 2'd0,
      PORT_IDATA  = 2'd1,
      PORT_STATUS = 2'd2,
      PORT_PIO    = 2'd3
   } port_e;

   typedef struct packed {
      logic w16;
      logic stereo;
   } fmt_t;

   // position of the final byte of a sample for a format
   function automatic logic [1:0] last_pos(fmt_t f);
      return {f.w16 & f.stereo, f.w16 | f.stereo};
   endfunction

   // bit offset of byte slot p inside a {right,left} sample
   function automatic int unsigned byte_off(logic [1:0] p, fmt_t f, int unsigned cw, int unsigned bw);
      logic ch;
      logic hi;
      ch = f.stereo ? (f.w16 ? p[1] : p[0]) : 1'b0;
      hi = f.w16 & p[0];
      return (ch ? cw : 0) + (hi ? bw : 0);
   endfunction

   function automatic logic is_upper(logic [1:0] p, fmt_t f);
      return !f.w16 | p[0];
   endfunction

   function automatic logic is_left(logic [1:0] p, fmt_t f);
      return !f.stereo | (f.w16 ? !p[1] : !p[0]);
   endfunction
endpackage

// File: rtl/codec_ctl_regs.sv
module codec_ctl_regs
   import codec_pio_pkg::*;
#(
   parameter int BW        = BYTE_W,
   parameter int IDX_W     = 4,
   parameter int RESET_IDX = 4
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             init_busy,
   input  logic             irq_event,
   input  logic             wr_idx,
   input  logic             wr_dat,
   input  logic             wr_stat,
   input  logic [BW-1:0]    wdata,
   input  logic             ovr,
   input  logic             unr,
   output logic [BW-1:0]    idx_rd,
   output logic [BW-1:0]    dat_rd,
   output fmt_t             fmt,
   output logic             fmt_load,
   output logic             cap_en,
   output logic             pb_en,
   output logic             ien,
   output logic             trd,
   output logic             int_st
);
   localparam logic [BW-1:0] INIT_READ = BW'(1) << (BW-1);

   if (IDX_W + 4 != BW) begin : g_bad_width
      $error("IDX_W must fill the bits above the four control bits");
   end
   if (RESET_IDX >= (1 << IDX_W)) begin : g_bad_reset
      $error("RESET_IDX does not fit IDX_W");
   end

   logic [IDX_W-1:0] idx;
   logic             mce;
   logic             wr_ok_idx, wr_ok_dat;

   assign wr_ok_idx = wr_idx && !init_busy;
   assign wr_ok_dat = wr_dat && !init_busy;
   assign fmt_load  = wr_ok_dat && mce && (idx == IDX_W'(0));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx    <= IDX_W'(RESET_IDX);
         mce    <= 1'b0;
         trd    <= 1'b0;
         fmt    <= '0;
         cap_en <= 1'b0;
         pb_en  <= 1'b0;
         ien    <= 1'b0;
         int_st <= 1'b0;
      end else begin
         if (wr_ok_idx) begin
            idx <= wdata[BW-1 -: IDX_W];
            trd <= wdata[2];
            mce <= wdata[1];
         end
         if (wr_ok_dat) begin
            case (idx)
               IDX_W'(0): if (mce) fmt <= fmt_t'(wdata[1:0]);
               IDX_W'(1): if (mce) {cap_en, pb_en} <= wdata[1:0];
               IDX_W'(2): ien <= wdata[1];
               default: ;
            endcase
         end
         if (irq_event)    int_st <= 1'b1;
         else if (wr_stat) int_st <= 1'b0;
      end
   end

   always_comb begin
      idx_rd = init_busy ? INIT_READ : {idx, 1'b0, trd, mce, init_busy};
      dat_rd = '0;
      if (init_busy) dat_rd = INIT_READ;
      else begin
         case (idx)
            IDX_W'(0): dat_rd = BW'(fmt);
            IDX_W'(1): dat_rd = BW'({cap_en, pb_en});
            IDX_W'(2): dat_rd = BW'({ien, 1'b0});
            IDX_W'(3): dat_rd = BW'({unr, ovr});
            default:   dat_rd = '0;
         endcase
      end
   end
endmodule

// File: rtl/codec_cap_unpack.sv
module codec_cap_unpack
   import codec_pio_pkg::*;
#(
   parameter int BW = BYTE_W,
   parameter int CW = CH_W
)(
   input  logic            clk,
   input  logic            rst_n,
   input  fmt_t            fmt,
   input  logic            fmt_load,
   input  logic            cap_valid,
   input  logic [2*CW-1:0] cap_data,
   input  logic            rd_pio,
   output logic [BW-1:0]   byte_o,
   output logic [1:0]      ptr,
   output logic [1:0]      last,
   output logic            ready,
   output logic            ovr
);
   if (CW != 2*BW) begin : g_bad_cw
      $error("channel width must be two bytes");
   end

   logic [2*CW-1:0] smp;

   assign last = last_pos(fmt);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         smp   <= '0;
         ptr   <= '0;
         ready <= 1'b0;
         ovr   <= 1'b0;
      end else if (fmt_load) begin
         ptr   <= '0;
         ready <= 1'b0;
      end else if (cap_valid) begin
         smp   <= cap_data;
         ptr   <= '0;
         ready <= 1'b1;
         ovr   <= ready;
      end else if (rd_pio) begin
         if (ptr != last) ptr <= ptr + 2'd1;
         else             ready <= 1'b0;
      end
   end

   assign byte_o = smp[byte_off(ptr, fmt, CW, BW) +: BW];
endmodule

// File: rtl/codec_pb_pack.sv
module codec_pb_pack
   import codec_pio_pkg::*;
#(
   parameter int BW = BYTE_W,
   parameter int CW = CH_W
)(
   input  logic            clk,
   input  logic            rst_n,
   input  fmt_t            fmt,
   input  logic            fmt_load,
   input  logic            wr_pio,
   input  logic [BW-1:0]   wdata,
   input  logic            pb_req,
   output logic [2*CW-1:0] pb_data,
   output logic [1:0]      ptr,
   output logic            full,
   output logic            unr
);
   logic [2*CW-1:0] buf_q;
   logic [1:0]      last;

   assign last = last_pos(fmt);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         buf_q   <= '0;
         pb_data <= '0;
         ptr     <= '0;
         full    <= 1'b0;
         unr     <= 1'b0;
      end else if (fmt_load) begin
         buf_q <= '0;
         ptr   <= '0;
         full  <= 1'b0;
      end else if (pb_req) begin
         if (full) begin
            pb_data <= buf_q;
            buf_q   <= '0;
            ptr     <= '0;
            full    <= 1'b0;
            unr     <= 1'b0;
         end else begin
            unr <= 1'b1;
         end
      end else if (wr_pio && !full) begin
         buf_q[byte_off(ptr, fmt, CW, BW) +: BW] <= wdata;
         if (ptr == last) full <= 1'b1;
         else             ptr  <= ptr + 2'd1;
      end
   end
endmodule

// File: rtl/codec_pio_regs.sv
module codec_pio_regs
   import codec_pio_pkg::*;
#(
   parameter int BW        = BYTE_W,
   parameter int CW        = CH_W,
   parameter int IDX_W     = 4,
   parameter int RESET_IDX = 4
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            init_busy,
   input  logic            irq_event,
   input  logic [1:0]      bus_addr,
   input  logic            bus_wr,
   input  logic            bus_rd,
   input  logic [BW-1:0]   bus_wdata,
   output logic [BW-1:0]   bus_rdata,
   input  logic            cap_valid,
   input  logic [2*CW-1:0] cap_data,
   input  logic            pb_req,
   output logic [2*CW-1:0] pb_data,
   output logic            cap_drq,
   output logic            pb_drq,
   output logic            irq,
   output logic            ovr_flag,
   output logic            unr_flag
);
   fmt_t          fmt;
   logic          fmt_load, cap_en, pb_en, ien, trd, int_st;
   logic [BW-1:0] idx_rd, dat_rd, cap_byte, status;
   logic [1:0]    cap_ptr, cap_last, pb_ptr;
   logic          cap_ready, pb_full, hold;

   codec_ctl_regs #(.BW(BW), .IDX_W(IDX_W), .RESET_IDX(RESET_IDX)) ctl_i (
      .clk, .rst_n, .init_busy, .irq_event,
      .wr_idx (bus_wr && bus_addr == PORT_INDEX),
      .wr_dat (bus_wr && bus_addr == PORT_IDATA),
      .wr_stat(bus_wr && bus_addr == PORT_STATUS),
      .wdata  (bus_wdata),
      .ovr    (ovr_flag),
      .unr    (unr_flag),
      .idx_rd, .dat_rd, .fmt, .fmt_load, .cap_en, .pb_en, .ien, .trd, .int_st
   );

   codec_cap_unpack #(.BW(BW), .CW(CW)) cap_i (
      .clk, .rst_n, .fmt, .fmt_load, .cap_valid, .cap_data,
      .rd_pio(bus_rd && bus_addr == PORT_PIO),
      .byte_o(cap_byte), .ptr(cap_ptr), .last(cap_last),
      .ready(cap_ready), .ovr(ovr_flag)
   );

   codec_pb_pack #(.BW(BW), .CW(CW)) pb_i (
      .clk, .rst_n, .fmt, .fmt_load,
      .wr_pio(bus_wr && bus_addr == PORT_PIO),
      .wdata (bus_wdata),
      .pb_req, .pb_data, .ptr(pb_ptr), .full(pb_full), .unr(unr_flag)
   );

   assign status = BW'({int_st, !pb_full, is_left(pb_ptr, fmt), is_upper(pb_ptr, fmt),
                        ovr_flag | unr_flag,
                        cap_ready, is_left(cap_ptr, fmt), is_upper(cap_ptr, fmt)});

   assign hold    = trd && int_st;
   assign cap_drq = cap_en && cap_ready && !hold;
   assign pb_drq  = pb_en && !pb_full && !hold;
   assign irq     = ien && int_st;

   always_comb begin
      case (port_e'(bus_addr))
         PORT_INDEX:  bus_rdata = idx_rd;
         PORT_IDATA:  bus_rdata = dat_rd;
         PORT_STATUS: bus_rdata = status;
         default:     bus_rdata = cap_byte;
      endcase
   end
endmodule

// File: rtl/codec_pio_regs_chk.sv
module codec_pio_regs_chk
   import codec_pio_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       init_busy,
   input logic [1:0] bus_addr,
   input logic       bus_wr,
   input logic       bus_rd,
   input logic [7:0] bus_rdata,
   input logic       irq_event,
   input logic       irq,
   input logic       cap_drq,
   input logic       pb_drq,
   input logic       cap_valid,
   input logic       pb_req,
   input logic       int_st,
   input logic       trd,
   input logic       ien,
   input logic [1:0] cap_ptr,
   input logic [1:0] cap_last,
   input logic [1:0] pb_ptr,
   input logic       pb_full,
   input logic       fmt_load
);
   a_r2_init_reads_80: assert property (@(posedge clk) disable iff (!rst_n)
      (init_busy && bus_addr != PORT_STATUS && bus_addr != PORT_PIO) |-> bus_rdata == 8'h80);

   a_r5_int_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (int_st && !(bus_wr && bus_addr == PORT_STATUS)) |=> int_st);

   a_r5_int_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_event && bus_wr && bus_addr == PORT_STATUS) |=> !int_st);

   a_r6_pin_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ien && int_st));

   a_r4_requests_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (trd && int_st) |-> (!cap_drq && !pb_drq));

   a_r8_hold_last_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_ptr == cap_last && bus_rd && bus_addr == PORT_PIO && !cap_valid && !fmt_load)
      |=> cap_ptr == $past(cap_ptr));

   a_r9_full_ignores_write: assert property (@(posedge clk) disable iff (!rst_n)
      (pb_full && bus_wr && bus_addr == PORT_PIO && !pb_req && !fmt_load)
      |=> (pb_full && $stable(pb_ptr)));
endmodule

bind codec_pio_regs codec_pio_regs_chk chk_i (.*);

// File: tb/codec_pio_regs_tb_top.sv
module codec_pio_regs_tb_top;
   localparam time CLK_PERIOD = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        init_busy = 1'b0, irq_event = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        cap_valid = 1'b0;
   logic [31:0] cap_data = '0;
   logic        pb_req = 1'b0;
   logic [31:0] pb_data;
   logic        cap_drq, pb_drq, irq, ovr_flag, unr_flag;

   int n_cmp = 0, n_bad = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];
   bit         done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   codec_pio_regs dut_i (.*);

   task automatic cmp(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // monitor: pops an expected byte for every read strobe
   always @(negedge clk) begin
      if (bus_rd && exp_q.size() > 0) begin
         cmp(32'(bus_rdata), 32'(exp_q.pop_front()), tag_q.pop_front());
      end
   end

   task automatic op(input logic [1:0] a, input logic w, input logic r, input logic [7:0] d);
      @(posedge clk); #1;
      bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = d;
      @(posedge clk); #1;
      bus_wr = 1'b0; bus_rd = 1'b0;
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      op(a, 1'b1, 1'b0, d);
   endtask

   task automatic rd(input logic [1:0] a, input logic [7:0] e, input string tag);
      exp_q.push_back(e);
      tag_q.push_back(tag);
      op(a, 1'b0, 1'b1, 8'h00);
   endtask

   task automatic cap(input logic [31:0] d);
      @(posedge clk); #1; cap_valid = 1'b1; cap_data = d;
      @(posedge clk); #1; cap_valid = 1'b0;
   endtask

   task automatic pbreq();
      @(posedge clk); #1; pb_req = 1'b1;
      @(posedge clk); #1; pb_req = 1'b0;
   endtask

   task automatic event_pulse();
      @(posedge clk); #1; irq_event = 1'b1;
      @(posedge clk); #1; irq_event = 1'b0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      rd(2'd0, 8'h40, "R1 index reset");
      rd(2'd2, 8'h73, "R7 status reset");
      #1 cmp(32'(pb_drq), 32'd0, "R4 pb_drq reset");
      // R2 initialisation lockout
      init_busy = 1'b1;
      rd(2'd0, 8'h80, "R2 index during init");
      wr(2'd0, 8'h52);
      wr(2'd1, 8'hFF);
      rd(2'd1, 8'h80, "R2 data during init");
      init_busy = 1'b0;
      rd(2'd0, 8'h40, "R2 index write ignored");
      // R3 unlock gating
      wr(2'd0, 8'h00);
      rd(2'd0, 8'h00, "R1 index fields");
      wr(2'd1, 8'h03);
      rd(2'd1, 8'h00, "R3 locked format write");
      wr(2'd0, 8'h02);
      rd(2'd0, 8'h02, "R1 unlock bit");
      wr(2'd1, 8'h03);
      rd(2'd1, 8'h03, "R3 unlocked format write");
      wr(2'd0, 8'h12);
      wr(2'd1, 8'h03);
      rd(2'd1, 8'h03, "R3 enables");
      wr(2'd0, 8'h22);
      wr(2'd1, 8'h02);
      rd(2'd1, 8'h02, "R6 enable register");
      wr(2'd0, 8'h52);
      wr(2'd1, 8'hFF);
      rd(2'd1, 8'h00, "R12 unimplemented index");
      wr(2'd0, 8'h32);
      wr(2'd1, 8'hFF);
      rd(2'd1, 8'h00, "R12 flags read-only");
      wr(2'd0, 8'h00);
      // R8 capture, 16-bit stereo
      cap(32'hDDCC_BBAA);
      rd(2'd2, 8'h66, "R7 status capture ready");
      #1 cmp(32'(cap_drq), 32'd1, "R4 cap_drq ready");
      rd(2'd3, 8'hAA, "R8 left low");
      rd(2'd3, 8'hBB, "R8 left high");
      rd(2'd3, 8'hCC, "R8 right low");
      rd(2'd3, 8'hDD, "R8 right high");
      rd(2'd3, 8'hDD, "R8 hold last byte");
      rd(2'd2, 8'h61, "R7 status drained");
      #1 cmp(32'(cap_drq), 32'd0, "R4 cap_drq drained");
      // R10 overrun
      cap(32'h1122_3344);
      cap(32'h5566_7788);
      #1 cmp(32'(ovr_flag), 32'd1, "R10 overrun flag");
      wr(2'd0, 8'h30);
      rd(2'd1, 8'h01, "R11 flag register overrun");
      rd(2'd2, 8'h6E, "R7 status with overrun");
      rd(2'd3, 8'h88, "R8 new sample restarts");
      // R11 underrun
      pbreq();
      #1 cmp(32'(unr_flag), 32'd1, "R11 underrun flag");
      cmp(pb_data, 32'h0, "R11 pb_data unchanged");
      rd(2'd1, 8'h03, "R11 flag register both");
      // R9 playback build
      wr(2'd3, 8'h10);
      wr(2'd3, 8'h20);
      rd(2'd2, 8'h4F, "R7 status mid playback");
      wr(2'd3, 8'h30);
      wr(2'd3, 8'h40);
      rd(2'd2, 8'h1F, "R7 status playback full");
      #1 cmp(32'(pb_drq), 32'd0, "R4 pb_drq full");
      wr(2'd3, 8'h99);
      pbreq();
      #1 cmp(pb_data, 32'h4030_2010, "R9 assembled sample");
      cmp(32'(unr_flag), 32'd0, "R11 underrun cleared");
      // 8-bit mono
      wr(2'd0, 8'h02);
      wr(2'd1, 8'h00);
      wr(2'd0, 8'h00);
      wr(2'd3, 8'h5A);
      wr(2'd3, 8'h77);
      pbreq();
      #1 cmp(pb_data, 32'h0000_005A, "R9 mono byte sample");
      cap(32'h1234_ABCD);
      rd(2'd3, 8'hCD, "R8 mono byte");
      rd(2'd3, 8'hCD, "R8 mono repeat");
      #1 cmp(32'(ovr_flag), 32'd0, "R10 overrun cleared");
      // R5 / R6 / R4 interrupt
      event_pulse();
      #1 cmp(32'(irq), 32'd1, "R6 irq enabled");
      rd(2'd2, 8'hF3, "R5 sticky status");
      wr(2'd0, 8'h24);
      #1 cmp(32'(pb_drq), 32'd0, "R4 stop on interrupt");
      wr(2'd2, 8'h5C);
      #1 cmp(32'(irq), 32'd0, "R5 write clears");
      cmp(32'(pb_drq), 32'd1, "R4 requests resume");
      wr(2'd1, 8'h00);
      event_pulse();
      #1 cmp(32'(irq), 32'd0, "R6 irq masked");
      rd(2'd2, 8'hF3, "R6 status still set");
      repeat (2) @(posedge clk);
      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (20000) @(posedge clk);
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule